// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block is a hardware sequencer. It turns a single request into the strobe sequence that a PHY's control-register bus expects. A requester presents an operation code, a 16-bit register address, 16-bit write data and a 16-bit merge mask through a valid/ready pair. The master then drives a 20-bit control word that carries the 16-bit data-in field and four strobes. It watches a 17-bit status word that carries the acknowledge and the 16-bit data-out field.

Every strobe is a full four-phase handshake. The master raises the strobe and waits for acknowledge to rise. It then removes the strobe while the data-in value stays in place, and waits for acknowledge to fall. An access always begins by capturing the address. A read, a write, or a read followed by a masked write to the same address comes after it. When the access ends, the master gives back the read data and a one-cycle completion pulse. If any acknowledge wait runs longer than a programmable number of cycles, the pulse also carries an error flag.

Top module: `crbm_master`

## Requirements
- R1: `req_ready` is high only while the master is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows.
- R2: Each access opens with an address phase. The address sits on control bits 17:2 with no strobe for two cycles. Then the capture-address strobe (bit 19) rises while the address stays on the field.
- R3: After any strobe rises, it is held until acknowledge (status bit 16) is seen high. In the next cycle it is removed while the data-in field keeps its value, and the master waits for acknowledge to read low before it moves on.
- R4: The read step drives the whole control word to zero for one cycle. It then raises the read strobe (bit 1) alone, with data-in at zero. It captures status bits 15:0 while acknowledge is high, then holds the control word at zero until acknowledge clears.
- R5: The write step presents the data on bits 17:2 for two cycles and then handshakes the capture-data strobe (bit 18). After that it handshakes the write strobe (bit 0) with the same data still on the field.
- R6: Operation codes are 0 = read, 1 = write, 2 = read-modify-write. Code 3 is handled exactly as a read.
- R7: A read-modify-write does a complete read and then a complete write (with its own address phase) to the same address. The value written is `(old & ~mask) | (wdata & mask)`. `rsp_rdata` returns the old value.
- R8: An acknowledge wait that has lasted `tmo_limit` cycles after its first cycle, and still sees no expected acknowledge level in that cycle, ends the access. In the next cycle the control word is zero, `rsp_done` and `rsp_err` both pulse, and the master is idle. An acknowledge that arrives in that final cycle wins over the timeout.
- R9: A completed access gives a one-cycle `rsp_done` with `rsp_err` low. For read, code 3 and read-modify-write, `rsp_rdata` then holds the captured value.
- R10: At most one of the four strobes is high in any cycle.
- R11: After reset `req_ready` is high, and the control word, `rsp_done` and `rsp_err` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request will be taken |
| req_op | input | 2 | Operation code (0 read, 1 write, 2 read-modify-write, 3 read) |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 16 | Bits of the old value replaced in read-modify-write |
| tmo_limit | input | 12 | Acknowledge-wait limit in cycles |
| ctrl_word | output | 20 | Bus control: bit 0 write, bit 1 read, 17:2 data-in, 18 capture-data, 19 capture-address |
| stat_word | input | 17 | Bus status: 15:0 data-out, 16 acknowledge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Acknowledge timeout, valid with rsp_done |
| rsp_rdata | output | 16 | Read value (old value for read-modify-write) |

## Verification
An acknowledge can arrive in exactly the cycle in which the wait counter reaches its limit. This is the case where completion and timeout fall in the same cycle. The bench's PHY model delays its acknowledge by a programmable number of edges. With a limit of five, a delay of four puts the acknowledge on that final cycle, and the access has to finish clean with correct read data. A delay of five has to give the error pulse with a quiet control word. Acknowledges that never come, and acknowledges stuck high during a release, are also driven to reach the timeout on both kinds of wait.

// File: rtl/crbm_pkg.sv
package crbm_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_RSVD  = 2'd3
  } crbm_op_e;

  // Sequencer steps: *_SET present data without strobe, *_STB wait ack high,
  // *_REL wait ack low with strobe removed.
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_ASET  = 4'd1,
    ST_ASTB  = 4'd2,
    ST_AREL  = 4'd3,
    ST_RZERO = 4'd4,
    ST_RSTB  = 4'd5,
    ST_RREL  = 4'd6,
    ST_DSET  = 4'd7,
    ST_DSTB  = 4'd8,
    ST_DREL  = 4'd9,
    ST_WSET  = 4'd10,
    ST_WSTB  = 4'd11,
    ST_WREL  = 4'd12
  } crbm_state_e;

endpackage

// File: rtl/crbm_timer.sv
module crbm_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          restart,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = busy | restart;

  always_comb begin
    if (restart)               cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/crbm_merge.sv
module crbm_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] merged
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign merged[b] = mask[b] ? new_val[b] : old_val[b];
  end
endmodule

// File: rtl/crbm_seq.sv
module crbm_seq
  import crbm_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_mask,
  input  logic [TW-1:0] tmo_limit,
  input  logic          ack,
  input  logic [DW-1:0] dout,
  input  logic [TW-1:0] cnt,
  input  logic [DW-1:0] merged,
  output logic          restart,
  output logic          busy,
  output crbm_state_e   state,
  output logic [DW-1:0] addr_hold,
  output logic [DW-1:0] data_hold,
  output logic [DW-1:0] mask_hold,
  output logic [DW-1:0] rdata_hold,
  output logic          done,
  output logic          err
);
  localparam logic [TW-1:0] SETUP_LAST = TW'(1);

  crbm_state_e   state_q, state_d;
  crbm_op_e      op_q;
  logic [DW-1:0] addr_q, wdat_q, mask_q, rdata_q;
  logic          wpass_q;
  logic          done_q, done_d, err_q, err_d;
  logic          accept, lat_rd, go_wpass;
  logic          wait_hi, wait_lo, met, expire, rd_path;

  assign wait_hi = (state_q == ST_ASTB) || (state_q == ST_RSTB) ||
                   (state_q == ST_DSTB) || (state_q == ST_WSTB);
  assign wait_lo = (state_q == ST_AREL) || (state_q == ST_RREL) ||
                   (state_q == ST_DREL) || (state_q == ST_WREL);
  assign met     = wait_hi ? ack : ~ack;
  assign expire  = (wait_hi | wait_lo) & ~met & (cnt == tmo_limit);
  assign rd_path = (op_q == OP_READ) || (op_q == OP_RSVD) ||
                   ((op_q == OP_RMW) && !wpass_q);

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    lat_rd   = 1'b0;
    go_wpass = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid) begin accept = 1'b1; state_d = ST_ASET; end
      ST_ASET:  if (cnt == SETUP_LAST) state_d = ST_ASTB;
      ST_ASTB:  if (ack) state_d = ST_AREL;
      ST_AREL:  if (!ack) state_d = rd_path ? ST_RZERO : ST_DSET;
      ST_RZERO: state_d = ST_RSTB;
      ST_RSTB:  if (ack) begin lat_rd = 1'b1; state_d = ST_RREL; end
      ST_RREL: begin
        if (!ack) begin
          if ((op_q == OP_RMW) && !wpass_q) begin
            go_wpass = 1'b1;
            state_d  = ST_ASET;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_DSET:  if (cnt == SETUP_LAST) state_d = ST_DSTB;
      ST_DSTB:  if (ack) state_d = ST_DREL;
      ST_DREL:  if (!ack) state_d = ST_WSET;
      ST_WSET:  state_d = ST_WSTB;
      ST_WSTB:  if (ack) state_d = ST_WREL;
      ST_WREL:  if (!ack) begin done_d = 1'b1; state_d = ST_IDLE; end
      default:  state_d = ST_IDLE;
    endcase
    if (expire) begin
      state_d  = ST_IDLE;
      done_d   = 1'b1;
      err_d    = 1'b1;
      lat_rd   = 1'b0;
      go_wpass = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdat_q  <= '0;
      mask_q  <= '0;
      wpass_q <= 1'b0;
    end else if (accept) begin
      op_q    <= crbm_op_e'(req_op);
      addr_q  <= req_addr;
      wdat_q  <= req_wdata;
      mask_q  <= req_mask;
      wpass_q <= 1'b0;
    end else if (go_wpass) begin
      wdat_q  <= merged;
      wpass_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (lat_rd) rdata_q <= dout;
  end

  assign restart    = (state_d != state_q);
  assign busy       = (state_q != ST_IDLE);
  assign state      = state_q;
  assign addr_hold  = addr_q;
  assign data_hold  = wdat_q;
  assign mask_hold  = mask_q;
  assign rdata_hold = rdata_q;
  assign done       = done_q;
  assign err        = err_q;
endmodule

// File: rtl/crbm_master.sv
module crbm_master
  import crbm_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_mask,
  input  logic [TW-1:0] tmo_limit,
  output logic [DW+3:0] ctrl_word,
  input  logic [DW:0]   stat_word,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  localparam int BIT_WR   = 0;
  localparam int BIT_RD   = 1;
  localparam int DIN_LO   = 2;
  localparam int BIT_CAPD = DW + 2;
  localparam int BIT_CAPA = DW + 3;

  crbm_state_e   state;
  logic [DW-1:0] addr_hold, data_hold, mask_hold, rdata_hold, merged;
  logic [TW-1:0] cnt;
  logic          restart, busy, ack;
  logic [DW-1:0] dout;

  assign ack  = stat_word[DW];
  assign dout = stat_word[DW-1:0];

  crbm_seq #(.DW(DW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .tmo_limit(tmo_limit),
    .ack(ack), .dout(dout), .cnt(cnt), .merged(merged),
    .restart(restart), .busy(busy), .state(state),
    .addr_hold(addr_hold), .data_hold(data_hold), .mask_hold(mask_hold),
    .rdata_hold(rdata_hold), .done(rsp_done), .err(rsp_err)
  );

  crbm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .restart(restart), .cnt(cnt)
  );

  crbm_merge #(.DW(DW)) u_merge (
    .old_val(rdata_hold), .new_val(data_hold), .mask(mask_hold), .merged(merged)
  );

  always_comb begin
    ctrl_word = '0;
    unique case (state)
      ST_ASET, ST_AREL: ctrl_word[DIN_LO +: DW] = addr_hold;
      ST_ASTB: begin
        ctrl_word[DIN_LO +: DW] = addr_hold;
        ctrl_word[BIT_CAPA]     = 1'b1;
      end
      ST_RSTB: ctrl_word[BIT_RD] = 1'b1;
      ST_DSET, ST_DREL, ST_WSET, ST_WREL: ctrl_word[DIN_LO +: DW] = data_hold;
      ST_DSTB: begin
        ctrl_word[DIN_LO +: DW] = data_hold;
        ctrl_word[BIT_CAPD]     = 1'b1;
      end
      ST_WSTB: begin
        ctrl_word[DIN_LO +: DW] = data_hold;
        ctrl_word[BIT_WR]       = 1'b1;
      end
      default: ctrl_word = '0;
    endcase
  end

  assign req_ready = ~busy;
  assign rsp_rdata = rdata_hold;
endmodule

// File: rtl/crbm_master_chk.sv
module crbm_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [DW+3:0] ctrl_word,
  input logic          ack,
  input logic          rsp_done,
  input logic          rsp_err
);
  logic [3:0]    stb;
  logic [DW-1:0] din;

  assign stb = {ctrl_word[DW+3], ctrl_word[DW+2], ctrl_word[1], ctrl_word[0]};
  assign din = ctrl_word[DW+1:2];

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_capa_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[DW+3]) |-> ($past(stb) == 4'd0) && ($past(stb, 2) == 4'd0) &&
                               ($past(din) == din) && ($past(din, 2) == din));

  p_hold_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb != 4'd0) && !ack) |=> (stb == $past(stb)) || rsp_err);

  p_drop_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb != 4'd0) && ack) |=> (stb == 4'd0) && (din == $past(din)));

  p_read_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[1] |-> (din == '0));

  p_capd_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[DW+2]) |-> ($past(stb) == 4'd0) && ($past(stb, 2) == 4'd0) &&
                               ($past(din) == din));

  p_write_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[0]) |-> ($past(din) == din));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done && (ctrl_word == '0) && req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
endmodule

bind crbm_master crbm_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ctrl_word(ctrl_word), .ack(stat_word[DW]), .rsp_done(rsp_done), .rsp_err(rsp_err)
);

// File: tb/crbm_master_tb.sv
`timescale 1ns/1ps
module crbm_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0, req_wdata = '0, req_mask = '0;
  logic [11:0] tmo_limit = 12'd8;
  logic [19:0] ctrl_word;
  logic [16:0] stat_word;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  crbm_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .tmo_limit(tmo_limit), .ctrl_word(ctrl_word), .stat_word(stat_word),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // ---------------- PHY register model ----------------
  int          dly = 0;
  bit          mute = 1'b0;
  bit          stick = 1'b0;
  logic        ack_m;
  logic [15:0] dout_m, cur_a;
  int          mcnt;
  logic [15:0] phy_mem [16];
  logic [2:0]  slog [4096];
  int          slog_n;
  logic        stb_m;

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 16'h1111) ^ 16'h5A5A;
  endfunction

  assign stb_m     = ctrl_word[19] | ctrl_word[18] | ctrl_word[1] | ctrl_word[0];
  assign stat_word = {ack_m, dout_m};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0; dout_m <= '0; cur_a <= '0; mcnt <= 0; slog_n <= 0;
      for (int i = 0; i < 16; i++) phy_mem[i] <= init_val(i);
    end else if (stb_m && !ack_m) begin
      if (!mute) begin
        if (mcnt >= dly) begin
          ack_m <= 1'b1;
          mcnt  <= 0;
          slog_n <= slog_n + 1;
          if (ctrl_word[19]) begin
            cur_a <= ctrl_word[17:2]; slog[slog_n % 4096] <= 3'd1;
          end else if (ctrl_word[18]) begin
            slog[slog_n % 4096] <= 3'd2;
          end else if (ctrl_word[1]) begin
            dout_m <= phy_mem[cur_a[3:0]]; slog[slog_n % 4096] <= 3'd3;
          end else begin
            phy_mem[cur_a[3:0]] <= ctrl_word[17:2]; slog[slog_n % 4096] <= 3'd4;
          end
        end else begin
          mcnt <= mcnt + 1;
        end
      end
    end else if (!stb_m) begin
      mcnt <= 0;
      if (ack_m && !stick) ack_m <= 1'b0;
    end
  end

  // ---------------- bench reference ----------------
  logic [15:0] ref_mem [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd,
                        input logic [15:0] m, output logic [15:0] rd, output bit er,
                        output int ls);
    int g;
    ls = slog_n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready while busy", {31'd0, req_ready}, 32'd0);
    g = 0;
    while (!rsp_done && g < 3000) begin
      @(negedge clk);
      g++;
    end
    chk(rsp_done == 1'b1, "R9", "done seen", {31'd0, rsp_done}, 32'd1);
    chk(req_ready == 1'b1, "R1", "ready at done", {31'd0, req_ready}, 32'd1);
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  function automatic bit log_ok(int start, int n_now, logic [1:0] op);
    logic [2:0] e [5];
    int n;
    if (op == 2'd1)      begin e = '{3'd1, 3'd2, 3'd4, 3'd0, 3'd0}; n = 3; end
    else if (op == 2'd2) begin e = '{3'd1, 3'd3, 3'd1, 3'd2, 3'd4}; n = 5; end
    else                 begin e = '{3'd1, 3'd3, 3'd0, 3'd0, 3'd0}; n = 2; end
    if (n_now - start != n) return 1'b0;
    for (int k = 0; k < n; k++)
      if (slog[(start + k) % 4096] != e[k]) return 1'b0;
    return 1'b1;
  endfunction

  // full operation against the reference, success expected
  task automatic op_ok(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd,
                       input logic [15:0] m, input string req);
    logic [15:0] rd, old;
    bit er;
    int ls;
    old = ref_mem[a[3:0]];
    run_op(op, a, wd, m, rd, er, ls);
    chk(er == 1'b0, req, "no error", {31'd0, er}, 32'd0);
    chk(log_ok(ls, slog_n, op), (op == 2'd2) ? "R7" : (op == 2'd1) ? "R5" : "R4",
        "strobe order", slog_n - ls, 32'd0);
    if (op == 2'd1) begin
      ref_mem[a[3:0]] = wd;
    end else if (op == 2'd2) begin
      chk(rd == old, "R7", "rmw returns old", {16'd0, rd}, {16'd0, old});
      ref_mem[a[3:0]] = (old & ~m) | (wd & m);
    end else begin
      chk(rd == old, (op == 2'd3) ? "R6" : "R4", "read data", {16'd0, rd}, {16'd0, old});
    end
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    bit er;
    int ls;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 16; i++) ref_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready", {31'd0, req_ready}, 32'd1);
    chk(ctrl_word == '0, "R11", "ctrl", {12'd0, ctrl_word}, 32'd0);
    chk(rsp_done == 1'b0 && rsp_err == 1'b0, "R11", "done/err",
        {30'd0, rsp_done, rsp_err}, 32'd0);

    tmo_limit = 12'd8; dly = 1;
    op_ok(2'd0, 16'h0003, 16'h0000, 16'h0000, "R4");
    op_ok(2'd1, 16'h0005, 16'hBEEF, 16'h0000, "R5");
    op_ok(2'd0, 16'h0005, 16'h0000, 16'h0000, "R5");
    op_ok(2'd2, 16'h0005, 16'h1234, 16'h00FF, "R7");
    op_ok(2'd0, 16'h0005, 16'h0000, 16'h0000, "R7");
    op_ok(2'd2, 16'h0009, 16'hFFFF, 16'h0000, "R7");
    op_ok(2'd2, 16'h0009, 16'h8421, 16'hFFFF, "R7");
    op_ok(2'd0, 16'h0009, 16'h0000, 16'h0000, "R7");
    op_ok(2'd3, 16'h0007, 16'hDEAD, 16'hFFFF, "R6");
    op_ok(2'd0, 16'h0000, 16'h0000, 16'h0000, "R2");

    // R8 boundary: ack lands in the final allowed cycle
    tmo_limit = 12'd5; dly = 4;
    op_ok(2'd0, 16'h000A, 16'h0000, 16'h0000, "R8");
    op_ok(2'd1, 16'h000B, 16'h7777, 16'h0000, "R8");
    // R8 one cycle late
    dly = 5;
    run_op(2'd0, 16'h000A, 16'h0000, 16'h0000, rd, er, ls);
    chk(er == 1'b1, "R8", "late ack times out", {31'd0, er}, 32'd1);
    chk(ctrl_word == '0, "R8", "ctrl quiet on error", {12'd0, ctrl_word}, 32'd0);
    repeat (4) @(negedge clk);

    // R8 ack never comes
    dly = 0; mute = 1'b1; tmo_limit = 12'd3;
    run_op(2'd1, 16'h000C, 16'h1111, 16'h0000, rd, er, ls);
    chk(er == 1'b1, "R8", "missing ack", {31'd0, er}, 32'd1);
    chk(ctrl_word == '0, "R8", "ctrl after missing ack", {12'd0, ctrl_word}, 32'd0);
    mute = 1'b0;
    repeat (4) @(negedge clk);

    // R8 ack stuck high during a release wait
    stick = 1'b1;
    run_op(2'd1, 16'h000D, 16'h2222, 16'h0000, rd, er, ls);
    chk(er == 1'b1, "R8", "stuck ack", {31'd0, er}, 32'd1);
    chk(ctrl_word == '0, "R8", "ctrl after stuck ack", {12'd0, ctrl_word}, 32'd0);
    stick = 1'b0;
    repeat (4) @(negedge clk);
    tmo_limit = 12'd8;
    op_ok(2'd0, 16'h000D, 16'h0000, 16'h0000, "R8");
    op_ok(2'd0, 16'h000C, 16'h0000, 16'h0000, "R8");

    // constrained random mix
    for (int n = 0; n < 150; n++) begin
      logic [1:0]  op;
      logic [15:0] a, wd, m;
      int          lim;
      op  = 2'($urandom % 4);
      a   = 16'($urandom);
      wd  = 16'($urandom);
      m   = 16'($urandom);
      lim = 2 + int'($urandom % 14);
      tmo_limit = 12'(lim);
      dly = int'($urandom % lim);
      op_ok(op, a, wd, m, "R7");
    end

    // model contents against the reference
    for (int i = 0; i < 16; i++)
      chk(phy_mem[i] == ref_mem[i], "R5", "final register image",
          {16'd0, phy_mem[i]}, {16'd0, ref_mem[i]});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule